// File: doc/BRIEF.md
# Excluding Random Tag Generator

This block picks a 4-bit memory tag and places it in bits [59:56] of a 64-bit pointer. Tag values that a 16-bit exclusion mask forbids are skipped: bit k of the mask set means that tag k may not be chosen. The block runs in one of two modes.

In random mode the starting tag and a 16-bit seed come from an internal state word. The seed is stepped four times through a linear feedback shift register, and the four bits it produces form the offset. The exclusion mask is the OR of an operand mask and a configuration mask. When the search ends, the chosen tag and the advanced seed are written back into the state word. In offset mode the starting tag is taken from the incoming pointer's tag field. The offset comes from an input, only the configuration mask applies, and the state word is left alone.

The search moves by one tag position per clock. A request is accepted with a `start` pulse and ends with a one-cycle `done` pulse. The state word can be loaded and read through plain ports.

Top module: `excl_tag_gen`

## Requirements
- R1: After reset the state word reads 0, and `busy` and `done` are low.
- R2: Software can load the state word. A `st_load` pulse while idle, with no `start` in the same cycle, writes `st_wdata`, and `st_rdata` shows the new value from the next cycle on.
- R3: In random mode the offset comes from four LFSR steps. Each step forms fb = s[5]^s[3]^s[2]^s[0] and then sets s = {fb, s[15:1]}. The fb of step i (i = 0..3) becomes offset bit i.
- R4: In random mode the start tag is state[3:0], and the exclusion mask is `op_mask | cfg_mask`.
- R5: If the effective exclusion mask is 16'hFFFF, the result tag is 0.
- R6: With offset 0, the result is the start tag if that tag is allowed. Otherwise the tag is incremented modulo 16 until it reaches an allowed value.
- R7: With a nonzero offset N, the step "increment modulo 16 at least once, until an allowed value is reached" is applied N times, beginning at the start tag.
- R8: In offset mode (`mode`=1) the start tag is `ptr_in[59:56]` and the offset is `ofs_in`. Only `cfg_mask` excludes tags, `op_mask` has no effect, and the state word is unchanged.
- R9: After a random-mode request the state word becomes {new seed in [23:8], 4'b0000 in [7:4], result tag in [3:0]}.
- R10: `ptr_out` equals the pointer that was accepted with `start`, with bits [59:56] replaced by the result tag, and is valid while `done` is high.
- R11: `done` is high for exactly one cycle per accepted request, and `busy` is low whenever `done` is high. A `start` or `st_load` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_load | input | 1 | Load the state word (honoured only when idle) |
| st_wdata | input | 24 | Value to load into the state word |
| st_rdata | output | 24 | Current state word: seed [23:8], tag [3:0] |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 1 | 0 = random mode, 1 = offset mode |
| ptr_in | input | 64 | Pointer that receives the tag |
| op_mask | input | 16 | Operand exclusion mask (random mode only) |
| cfg_mask | input | 16 | Configuration exclusion mask |
| ofs_in | input | 4 | Explicit offset (offset mode) |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| tag_out | output | 4 | Result tag |
| ptr_out | output | 64 | Pointer carrying the result tag |

## Verification
The bench builds the block with its defaults: a 4-bit tag, a 16-bit seed and a 64-bit pointer with the tag at bit 56. With these values all 16 tag positions and every wrap from 15 to 0 can be exercised, including the fully excluded mask and a mask that leaves a single tag allowed. The longest walk, offset 15 with one allowed tag, keeps `busy` high for more than 200 cycles. That window is used to show that a late `start` and a late `st_load` leave the state word untouched.

// File: rtl/etg_pkg.sv
package etg_pkg;
    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_SETTLE = 2'd1,
        W_STEP   = 2'd2
    } walk_st_e;
endpackage

// File: rtl/etg_lfsr.sv
// Combinational chain of STEPS shift-register steps; taps at 5,3,2,0.
module etg_lfsr #(
    parameter int SEED_W = 16,
    parameter int STEPS  = 4
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o,
    output logic [STEPS-1:0]  bits_o
);
    logic [SEED_W-1:0] chain [0:STEPS];

    assign chain[0] = seed_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        logic fb;
        assign fb        = chain[g][5] ^ chain[g][3] ^ chain[g][2] ^ chain[g][0];
        assign bits_o[g] = fb;
        assign chain[g+1] = {fb, chain[g][SEED_W-1:1]};
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/etg_walker.sv
// Multi-cycle search over the exclusion mask, one tag position per cycle.
module etg_walker
    import etg_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [TAG_W-1:0]     tag_i,
    input  logic [TAG_W-1:0]     ofs_i,
    input  logic [(1<<TAG_W)-1:0] mask_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [TAG_W-1:0]     tag_o
);
    localparam int NTAG = 1 << TAG_W;

    typedef struct packed {
        walk_st_e          st;
        logic [TAG_W-1:0]  cur;
        logic [TAG_W-1:0]  rem;
        logic [NTAG-1:0]   mask;
        logic              done;
        logic [TAG_W-1:0]  res;
    } walk_t;

    walk_t q, d;
    logic  excl;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        excl   = q.mask[q.cur];
        case (q.st)
            W_IDLE: begin
                if (start_i) begin
                    d.mask = mask_i;
                    if (&mask_i) begin
                        d.res  = '0;
                        d.done = 1'b1;
                    end else if (ofs_i == '0) begin
                        d.st  = W_SETTLE;
                        d.cur = tag_i;
                    end else begin
                        d.st  = W_STEP;
                        d.cur = tag_i + 1'b1;
                        d.rem = ofs_i;
                    end
                end
            end
            W_SETTLE: begin
                if (excl) begin
                    d.cur = q.cur + 1'b1;
                end else begin
                    d.res  = q.cur;
                    d.done = 1'b1;
                    d.st   = W_IDLE;
                end
            end
            W_STEP: begin
                if (excl) begin
                    d.cur = q.cur + 1'b1;
                end else if (q.rem == TAG_W'(1)) begin
                    d.res  = q.cur;
                    d.done = 1'b1;
                    d.st   = W_IDLE;
                end else begin
                    d.rem = q.rem - 1'b1;
                    d.cur = q.cur + 1'b1;
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: W_IDLE, cur: '0, rem: '0, mask: '0, done: 1'b0, res: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != W_IDLE);
    assign done_o = q.done;
    assign tag_o  = q.res;

    // R5
    all_excl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && (&q.mask)) |-> (q.res == '0));

    // R6 R7
    res_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !(&q.mask)) |-> !q.mask[q.res]);

    // R11
    walk_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == W_IDLE));
endmodule

// File: rtl/excl_tag_gen.sv
module excl_tag_gen #(
    parameter int TAG_W   = 4,
    parameter int SEED_W  = 16,
    parameter int PTR_W   = 64,
    parameter int TAG_LSB = 56,
    parameter int STEPS   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_load,
    input  logic [SEED_W+7:0]   st_wdata,
    output logic [SEED_W+7:0]   st_rdata,
    input  logic                start,
    input  logic                mode,
    input  logic [PTR_W-1:0]    ptr_in,
    input  logic [(1<<TAG_W)-1:0] op_mask,
    input  logic [(1<<TAG_W)-1:0] cfg_mask,
    input  logic [TAG_W-1:0]    ofs_in,
    output logic                busy,
    output logic                done,
    output logic [TAG_W-1:0]    tag_out,
    output logic [PTR_W-1:0]    ptr_out
);
    localparam int NTAG     = 1 << TAG_W;
    localparam int SEED_LSB = 8;
    localparam int STATE_W  = SEED_W + SEED_LSB;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [SEED_W-1:0]  seed_nx;
        logic               rnd;
        logic [PTR_W-1:0]   ptr;
        logic [TAG_W-1:0]   tag;
        logic               done;
    } top_t;

    top_t q, d;

    logic [SEED_W-1:0] lfsr_seed;
    logic [STEPS-1:0]  lfsr_bits;
    logic              wk_busy, wk_done, accept;
    logic [TAG_W-1:0]  wk_tag, wk_start_tag, wk_ofs;
    logic [NTAG-1:0]   wk_mask;

    etg_lfsr #(.SEED_W(SEED_W), .STEPS(STEPS)) u_lfsr (
        .seed_i (q.state[SEED_LSB +: SEED_W]),
        .seed_o (lfsr_seed),
        .bits_o (lfsr_bits)
    );

    assign busy   = wk_busy | wk_done;
    assign accept = start & ~busy;

    always_comb begin
        if (mode) begin
            wk_start_tag = ptr_in[TAG_LSB +: TAG_W];
            wk_ofs       = ofs_in;
            wk_mask      = cfg_mask;
        end else begin
            wk_start_tag = q.state[TAG_W-1:0];
            wk_ofs       = TAG_W'(lfsr_bits);
            wk_mask      = op_mask | cfg_mask;
        end
    end

    etg_walker #(.TAG_W(TAG_W)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .tag_i   (wk_start_tag),
        .ofs_i   (wk_ofs),
        .mask_i  (wk_mask),
        .busy_o  (wk_busy),
        .done_o  (wk_done),
        .tag_o   (wk_tag)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (accept) begin
            d.rnd     = ~mode;
            d.seed_nx = lfsr_seed;
            d.ptr     = ptr_in;
        end else if (st_load && !busy) begin
            d.state = st_wdata;
        end
        if (wk_done) begin
            d.done = 1'b1;
            d.tag  = wk_tag;
            d.ptr[TAG_LSB +: TAG_W] = wk_tag;
            if (q.rnd) begin
                d.state = {q.seed_nx, {(SEED_LSB-TAG_W){1'b0}}, wk_tag};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign st_rdata = q.state;
    assign done     = q.done;
    assign tag_out  = q.tag;
    assign ptr_out  = q.ptr;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11
    start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_load |=> ($stable(st_rdata) || done));
endmodule

// File: tb/excl_tag_gen_tb.sv
module excl_tag_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_load = 1'b0;
    logic [23:0] st_wdata = '0;
    logic [23:0] st_rdata;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [63:0] ptr_in = '0;
    logic [15:0] op_mask = '0;
    logic [15:0] cfg_mask = '0;
    logic [3:0]  ofs_in = '0;
    logic        busy, done;
    logic [3:0]  tag_out;
    logic [63:0] ptr_out;

    int n_chk = 0;
    int n_err = 0;
    bit got_done;

    always #5 clk = ~clk;

    excl_tag_gen u_dut (
        .clk(clk), .rst_n(rst_n), .st_load(st_load), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .start(start), .mode(mode), .ptr_in(ptr_in),
        .op_mask(op_mask), .cfg_mask(cfg_mask), .ofs_in(ofs_in),
        .busy(busy), .done(done), .tag_out(tag_out), .ptr_out(ptr_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pick(input logic [3:0] st, input logic [3:0] ofs,
                                        input logic [15:0] m);
        logic [3:0] t = st;
        if (m == 16'hFFFF) return 4'd0;
        if (ofs == 0) begin
            while (m[t]) t = t + 1'b1;
        end else begin
            for (int k = 0; k < ofs; k++) begin
                t = t + 1'b1;
                while (m[t]) t = t + 1'b1;
            end
        end
        return t;
    endfunction

    function automatic logic [19:0] lfsr4(input logic [15:0] s);
        logic [15:0] x = s;
        logic [3:0]  o;
        logic        fb;
        for (int i = 0; i < 4; i++) begin
            fb   = x[5] ^ x[3] ^ x[2] ^ x[0];
            o[i] = fb;
            x    = {fb, x[15:1]};
        end
        return {x, o};
    endfunction

    task automatic load_state(input logic [23:0] v);
        @(negedge clk);
        st_load = 1'b1; st_wdata = v;
        @(negedge clk);
        st_load = 1'b0;
    endtask

    task automatic issue(input logic md, input logic [63:0] p, input logic [15:0] om,
                         input logic [15:0] cm, input logic [3:0] of);
        @(negedge clk);
        mode = md; ptr_in = p; op_mask = om; cfg_mask = cm; ofs_in = of; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        got_done = 1'b0;
        for (int i = 0; i < 2000 && !got_done; i++) begin
            if (done) got_done = 1'b1;
            else @(negedge clk);
        end
        check({req, " done seen"}, 64'(got_done), 64'd1);
    endtask

    // R1
    task automatic t_reset();
        check("R1 state", 64'(st_rdata), 64'd0);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
    endtask

    // R2 R3 R4 R9 R10: random mode from a loaded seed
    task automatic t_random(input logic [15:0] seed, input logic [3:0] st,
                            input logic [15:0] om, input logic [15:0] cm, input string tag);
        logic [19:0] lf;
        logic [3:0]  exp_t;
        logic [63:0] p = 64'hA5C3_1234_5678_9ABC;
        load_state({seed, 4'h0, st});
        check({"R2 load ", tag}, 64'(st_rdata), 64'({seed, 4'h0, st}));
        lf    = lfsr4(seed);
        exp_t = pick(st, lf[3:0], om | cm);
        issue(1'b0, p, om, cm, 4'h0);
        wait_done({"R11 ", tag});
        check({"R3 R4 tag ", tag}, 64'(tag_out), 64'(exp_t));
        check({"R10 ptr ", tag}, ptr_out, {p[63:60], exp_t, p[55:0]});
        @(negedge clk);
        check({"R11 pulse ", tag}, 64'(done), 64'd0);
        check({"R9 state ", tag}, 64'(st_rdata), 64'({lf[19:4], 4'h0, exp_t}));
    endtask

    // R8 R6 R7: offset mode
    task automatic t_offset(input logic [3:0] pt, input logic [3:0] of, input logic [15:0] cm,
                            input logic [3:0] exp_t, input string req);
        logic [23:0] st0 = st_rdata;
        logic [63:0] p   = {4'h7, pt, 56'h00F0_0D00_BEEF_01};
        issue(1'b1, p, 16'hFFFF, cm, of);
        wait_done(req);
        check({req, " tag"}, 64'(tag_out), 64'(exp_t));
        check({req, " model"}, 64'(exp_t), 64'(pick(pt, of, cm)));
        check("R10 ptr offset", ptr_out, {p[63:60], exp_t, p[55:0]});
        @(negedge clk);
        check("R8 state kept", 64'(st_rdata), 64'(st0));
    endtask

    // R11: start and load during a long walk are ignored
    task automatic t_busy_ignore();
        logic [23:0] st0 = st_rdata;
        issue(1'b1, {4'h0, 4'h4, 56'h0}, 16'h0, 16'hFFF7, 4'hF);
        check("R11 busy", 64'(busy), 64'd1);
        @(negedge clk);
        st_load = 1'b1; st_wdata = 24'h123456;
        @(negedge clk);
        st_load = 1'b0; mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R11 long");
        check("R7 single allowed", 64'(tag_out), 64'd3);
        check("R11 busy at done", 64'(busy), 64'd0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R11 no extra done", 64'(done), 64'd0);
        end
        check("R11 state untouched", 64'(st_rdata), 64'(st0));
    endtask

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_random(16'hACE1, 4'h5, 16'h0000, 16'h0000, "free");
        t_random(16'h1D2B, 4'hE, 16'h4100, 16'h0082, "masked");
        t_random(16'hFFFF, 4'h9, 16'hFF00, 16'h00FF, "allex");
        // R5 all excluded with a fixed value
        check("R5 zero tag", 64'(tag_out), 64'd0);
        t_random(16'h0000, 4'hF, 16'h0001, 16'h8000, "zero seed");
        // R6: start allowed, offset 0
        t_offset(4'h9, 4'h0, 16'h0000, 4'h9, "R6 allowed");
        // R6: start 15 excluded, wrap past excluded 0 to 1
        t_offset(4'hF, 4'h0, 16'h8001, 4'h1, "R6 wrap");
        // R7: start 14, two steps, 15 and 0 excluded -> 1 then 2
        t_offset(4'hE, 4'h2, 16'h8001, 4'h2, "R7 wrap");
        // R5 + R8: cfg all ones in offset mode
        t_offset(4'hB, 4'h3, 16'hFFFF, 4'h0, "R5 offset");
        // R8: op_mask ignored (issue drives op_mask all ones)
        t_offset(4'h3, 4'h5, 16'h0010, 4'h9, "R8 op ignored");
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule